// File: doc/BRIEF.md
# Banked Scratchpad with Conflict Replay

This block is an on-chip scratchpad built from 32 word-wide banks. It takes one vector request at a time. A request carries up to 32 lanes, and each lane has its own word address, an enable bit, write data and byte enables. The block breaks the request into the fewest passes that are free of bank conflicts. In each pass every bank does at most one word access. Lanes that ask for the same word in a bank are merged into that access: reads are broadcast to all of them, and writes are combined byte by byte. The lanes left over wait for later passes.

A request is accepted with a valid/ready handshake. The whole request is either a read or a write. While passes remain, the block holds off new requests. One cycle after the last pass it raises a one-cycle response strobe and presents the read data of all lanes together. It also reports how many passes the request used, which shows the conflict degree of the access pattern.

The control is a three-state machine:
- `ST_IDLE` accepts a request. It moves to `ST_RUN` when at least one lane is enabled, and straight to `ST_RESP` when no lane is enabled.
- `ST_RUN` performs one pass per cycle. It moves to `ST_RESP` once the pass being served empties the pending set.
- `ST_RESP` drives the response strobe for one cycle and then returns to `ST_IDLE`.

Top module: `spm_banked`

## Requirements
- R1: A lane's word address selects bank = address mod 32 (the low 5 bits) and row = address / 32. A word written at an address is returned by a later read of the same address.
- R2: A request whose enabled lanes hit 32 different banks completes in one pass (rsp_passes = 1). Examples are lane address = lane×1 and lane address = lane×33.
- R3: Lanes that target n different words of one bank take n passes. Lane address = lane×32 with all 32 lanes enabled takes 32 passes. rsp_passes never exceeds 32.
- R4: Any number of lanes reading the same word are served together in one pass, and each of them receives that word.
- R5: In each pass, every bank serves the word of its lowest-numbered pending lane. All pending lanes that target that same word are served with it, and the served lanes leave the pending set.
- R6: req_ready is low from the acceptance edge until the response. rsp_valid is high for exactly one cycle, sampled passes+1 cycles after the acceptance edge.
- R7: When several lanes of one pass write the same word, each byte takes the data of the highest-numbered lane whose byte enable for that byte is set.
- R8: Byte enable bit k of a lane (req_be[lane*4+k]) writes bits 8k+7:8k of the word. Bytes whose enable is clear keep their old value.
- R9: Lanes whose req_active bit is 0 are never scheduled. Their write data has no effect, and their field of rsp_rdata is zero.
- R10: A request with no enabled lane produces rsp_valid in the cycle after acceptance, with rsp_passes = 0.
- R11: After reset req_ready = 1, rsp_valid = 0 and rsp_passes = 0. rsp_passes keeps the count of the last request until the next one is accepted.
- R12: Conflicts are evaluated only within one request. Back-to-back requests that hit the same bank each take a single pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be accepted (idle) |
| req_write | input | 1 | 1 = write request, 0 = read request |
| req_active | input | LANES | Per-lane enable |
| req_addr | input | LANES*ADDR_W | Lane j word address at [j*ADDR_W +: ADDR_W] |
| req_wdata | input | LANES*WORD_W | Lane j write data at [j*WORD_W +: WORD_W] |
| req_be | input | LANES*WORD_W/8 | Lane j byte enables at [j*4 +: 4] |
| rsp_valid | output | 1 | One-cycle completion strobe |
| rsp_rdata | output | LANES*WORD_W | Lane j read data at [j*WORD_W +: WORD_W] |
| rsp_passes | output | clog2(LANES+1) | Passes used by the last request |

## Verification
The bench builds the block with its default parameters: 32 lanes, 32 banks, 10-bit word addresses (32 rows per bank) and 32-bit words. The address space therefore holds both the lane×33 padded column and the lane×32 column that lands entirely in one bank. This lets the bench compare the one-pass and 32-pass extremes, the 2-way and 16-way strides in between, and broadcast patterns that sweep the whole warp. The small row count also lets stride-64 patterns pile several words onto one bank while staying inside the array.

// File: rtl/spm_pkg.sv
package spm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_RESP = 2'd2
    } spm_state_e;

endpackage

// File: rtl/spm_bank.sv
// One word-wide bank with per-byte write enables and a combinational read port.
module spm_bank #(
    parameter int ROWS   = 32,
    parameter int WORD_W = 32,
    localparam int ROW_W = $clog2(ROWS),
    localparam int BE_W  = WORD_W / 8
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ROW_W-1:0]  row,
    input  logic [WORD_W-1:0] wdata,
    input  logic [BE_W-1:0]   wbe,
    output logic [WORD_W-1:0] rdata
);

    logic [WORD_W-1:0] mem [ROWS];

    always_ff @(posedge clk) begin
        for (int k = 0; k < BE_W; k++) begin
            if (wr_en && wbe[k]) begin
                mem[row][k*8 +: 8] <= wdata[k*8 +: 8];
            end
        end
    end

    assign rdata = mem[row];

endmodule

// File: rtl/spm_pass_sched.sv
// Picks, for every bank, the word of its lowest pending lane and marks every
// pending lane that targets that word as served in this pass.
module spm_pass_sched #(
    parameter int LANES  = 32,
    parameter int BANKS  = 32,
    parameter int ADDR_W = 10,
    localparam int BANK_W = $clog2(BANKS),
    localparam int ROW_W  = ADDR_W - BANK_W
) (
    input  logic [LANES-1:0]        pending,
    input  logic [LANES*ADDR_W-1:0] addr,
    output logic [LANES-1:0]        serve,
    output logic [BANKS-1:0]        bank_act,
    output logic [BANKS*ROW_W-1:0]  bank_row
);

    logic [BANK_W-1:0] lbank [LANES];
    logic [ROW_W-1:0]  lrow  [LANES];
    logic [ROW_W-1:0]  lead_r [BANKS];
    logic [BANKS-1:0]  lead_v;

    for (genvar j = 0; j < LANES; j++) begin : g_split
        assign lbank[j] = addr[j*ADDR_W +: BANK_W];
        assign lrow[j]  = addr[j*ADDR_W + BANK_W +: ROW_W];
    end

    // leader per bank: scanning downward leaves the lowest pending lane
    always_comb begin
        for (int b = 0; b < BANKS; b++) begin
            lead_v[b] = 1'b0;
            lead_r[b] = '0;
            for (int i = LANES - 1; i >= 0; i--) begin
                if (pending[i] && (lbank[i] == BANK_W'(b))) begin
                    lead_v[b] = 1'b1;
                    lead_r[b] = lrow[i];
                end
            end
        end
    end

    always_comb begin
        for (int j = 0; j < LANES; j++) begin
            serve[j] = pending[j] && (lead_r[lbank[j]] == lrow[j]);
        end
    end

    assign bank_act = lead_v;

    for (genvar b = 0; b < BANKS; b++) begin : g_out
        assign bank_row[b*ROW_W +: ROW_W] = lead_r[b];
    end

endmodule

// File: rtl/spm_banked.sv
module spm_banked
    import spm_pkg::*;
#(
    parameter int LANES  = 32,
    parameter int BANKS  = 32,
    parameter int ADDR_W = 10,
    parameter int WORD_W = 32,
    localparam int BE_W   = WORD_W / 8,
    localparam int BANK_W = $clog2(BANKS),
    localparam int ROW_W  = ADDR_W - BANK_W,
    localparam int ROWS   = 1 << ROW_W,
    localparam int CNT_W  = $clog2(LANES + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic                    req_write,
    input  logic [LANES-1:0]        req_active,
    input  logic [LANES*ADDR_W-1:0] req_addr,
    input  logic [LANES*WORD_W-1:0] req_wdata,
    input  logic [LANES*BE_W-1:0]   req_be,
    output logic                    rsp_valid,
    output logic [LANES*WORD_W-1:0] rsp_rdata,
    output logic [CNT_W-1:0]        rsp_passes
);

    spm_state_e state_q, state_d;

    logic                    wr_q;
    logic [LANES*ADDR_W-1:0] addr_q;
    logic [LANES*WORD_W-1:0] wdata_q;
    logic [LANES*BE_W-1:0]   be_q;
    logic [LANES-1:0]        pending_q;
    logic [LANES*WORD_W-1:0] rdata_q;
    logic [CNT_W-1:0]        passes_q;

    logic [LANES-1:0]        serve;
    logic [BANKS-1:0]        bank_act;
    logic [BANKS*ROW_W-1:0]  bank_row;
    logic [WORD_W-1:0]       bank_rd [BANKS];
    logic [BANK_W-1:0]       lane_bank [LANES];

    logic accept;
    logic last_pass;

    assign accept    = req_valid && req_ready;
    assign last_pass = (pending_q & ~serve) == '0;

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        assign lane_bank[j] = addr_q[j*ADDR_W +: BANK_W];
    end

    spm_pass_sched #(
        .LANES  (LANES),
        .BANKS  (BANKS),
        .ADDR_W (ADDR_W)
    ) u_sched (
        .pending  (pending_q),
        .addr     (addr_q),
        .serve    (serve),
        .bank_act (bank_act),
        .bank_row (bank_row)
    );

    // per-bank write merge: later (higher) lanes override per byte
    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        logic [WORD_W-1:0] mw;
        logic [BE_W-1:0]   mbe;
        logic [WORD_W-1:0] rd;
        logic              we;

        always_comb begin
            mw  = '0;
            mbe = '0;
            for (int j = 0; j < LANES; j++) begin
                if (serve[j] && (lane_bank[j] == BANK_W'(b))) begin
                    for (int k = 0; k < BE_W; k++) begin
                        if (be_q[j*BE_W + k]) begin
                            mw[k*8 +: 8] = wdata_q[j*WORD_W + k*8 +: 8];
                            mbe[k]       = 1'b1;
                        end
                    end
                end
            end
        end

        assign we = (state_q == ST_RUN) && wr_q && bank_act[b];

        spm_bank #(
            .ROWS   (ROWS),
            .WORD_W (WORD_W)
        ) u_bank (
            .clk   (clk),
            .wr_en (we),
            .row   (bank_row[b*ROW_W +: ROW_W]),
            .wdata (mw),
            .wbe   (mbe),
            .rdata (rd)
        );

        assign bank_rd[b] = rd;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid) state_d = (req_active != '0) ? ST_RUN : ST_RESP;
            ST_RUN:  if (last_pass) state_d = ST_RESP;
            ST_RESP: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs decoded from state
    always_comb begin
        req_ready = 1'b0;
        rsp_valid = 1'b0;
        unique case (state_q)
            ST_IDLE: req_ready = 1'b1;
            ST_RUN:  ;
            ST_RESP: rsp_valid = 1'b1;
            default: ;
        endcase
    end

    // request capture and pass bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q      <= 1'b0;
            addr_q    <= '0;
            wdata_q   <= '0;
            be_q      <= '0;
            pending_q <= '0;
            rdata_q   <= '0;
            passes_q  <= '0;
        end else if (accept) begin
            wr_q      <= req_write;
            addr_q    <= req_addr;
            wdata_q   <= req_wdata;
            be_q      <= req_be;
            pending_q <= req_active;
            rdata_q   <= '0;
            passes_q  <= '0;
        end else if (state_q == ST_RUN) begin
            pending_q <= pending_q & ~serve;
            passes_q  <= passes_q + 1'b1;
            for (int j = 0; j < LANES; j++) begin
                if (serve[j] && !wr_q) begin
                    rdata_q[j*WORD_W +: WORD_W] <= bank_rd[lane_bank[j]];
                end
            end
        end
    end

    assign rsp_rdata  = rdata_q;
    assign rsp_passes = passes_q;

    // R5
    sched_progress_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN) |-> ((serve & pending_q) != '0));

    // R9
    serve_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN) |-> ((serve & ~pending_q) == '0));

    // R6
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R6
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R10
    empty_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && (req_active == '0)) |=> (rsp_valid && (rsp_passes == '0)));

    // R3
    pass_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_passes <= CNT_W'(LANES)));

    // R11
    passes_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_IDLE) && !req_valid) |=> $stable(rsp_passes));

endmodule

// File: tb/spm_banked_test.sv
module spm_banked_test;

    localparam int LANES = 32;
    localparam int AW    = 10;
    localparam int WW    = 32;
    localparam int WORDS = 1 << AW;

    typedef struct packed {
        logic        wr;
        logic [10:0] stride;
        logic [9:0]  base;
        logic [31:0] act;
        logic [5:0]  exp;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 11'd1,  10'd0,  32'hFFFF_FFFF, 6'd1},   // R2 write
        '{1'b0, 11'd1,  10'd0,  32'hFFFF_FFFF, 6'd1},   // R1 R2
        '{1'b1, 11'd1,  10'd32, 32'hFFFF_FFFF, 6'd1},
        '{1'b0, 11'd2,  10'd0,  32'hFFFF_FFFF, 6'd2},   // R3 2-way
        '{1'b1, 11'd33, 10'd0,  32'hFFFF_FFFF, 6'd1},   // R2 padded
        '{1'b0, 11'd33, 10'd0,  32'hFFFF_FFFF, 6'd1},
        '{1'b1, 11'd32, 10'd5,  32'hFFFF_FFFF, 6'd32},  // R3 worst
        '{1'b0, 11'd32, 10'd5,  32'hFFFF_FFFF, 6'd32},
        '{1'b0, 11'd0,  10'd7,  32'hFFFF_FFFF, 6'd1},   // R4
        '{1'b1, 11'd16, 10'd0,  32'hFFFF_FFFF, 6'd16},
        '{1'b0, 11'd16, 10'd0,  32'hFFFF_FFFF, 6'd16},
        '{1'b0, 11'd1,  10'd0,  32'h0000_00F0, 6'd1},   // R9
        '{1'b0, 11'd1,  10'd0,  32'h0000_0000, 6'd0},   // R10
        '{1'b1, 11'd64, 10'd3,  32'h0000_000F, 6'd4},
        '{1'b0, 11'd64, 10'd3,  32'h0000_000F, 6'd4},
        '{1'b0, 11'd31, 10'd1,  32'hFFFF_FFFF, 6'd1},
        '{1'b0, 11'd0,  10'd40, 32'hAAAA_AAAA, 6'd1}    // R4
    };

    logic clk = 1'b0;
    logic rst_n;
    logic req_valid, req_ready, req_write;
    logic [LANES-1:0]    req_active;
    logic [LANES*AW-1:0] req_addr;
    logic [LANES*WW-1:0] req_wdata;
    logic [LANES*4-1:0]  req_be;
    logic rsp_valid;
    logic [LANES*WW-1:0] rsp_rdata;
    logic [5:0] rsp_passes;

    always #10 clk = ~clk;

    spm_banked uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_write  (req_write),
        .req_active (req_active),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .req_be     (req_be),
        .rsp_valid  (rsp_valid),
        .rsp_rdata  (rsp_rdata),
        .rsp_passes (rsp_passes)
    );

    int nchk = 0;
    int nfail = 0;

    logic [31:0] model [WORDS];
    bit          known [WORDS];

    logic [AW-1:0] t_addr [LANES];
    logic [31:0]   t_wd   [LANES];
    logic [3:0]    t_be   [LANES];

    logic [LANES*WW-1:0] got_rd;
    logic [5:0]          got_passes;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // model update from the requirements: ascending lanes, per-byte override
    task automatic model_write(input logic [31:0] act);
        for (int l = 0; l < LANES; l++) begin
            if (act[l]) begin
                for (int k = 0; k < 4; k++) begin
                    if (t_be[l][k]) model[t_addr[l]][k*8 +: 8] = t_wd[l][k*8 +: 8];
                end
                known[t_addr[l]] = 1'b1;
            end
        end
    endtask

    // issues one request, checks R6 timing and the pass count
    task automatic issue(input logic wr, input logic [31:0] act, input int exp_p, input string tag);
        int  lat;
        bit  rdy_bad;
        @(negedge clk);
        req_write  = wr;
        req_active = act;
        for (int l = 0; l < LANES; l++) begin
            req_addr[l*AW +: AW] = t_addr[l];
            req_wdata[l*WW +: WW] = t_wd[l];
            req_be[l*4 +: 4]      = t_be[l];
        end
        req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        rdy_bad = 1'b0;
        while (!rsp_valid && lat < 200) begin
            if (req_ready) rdy_bad = 1'b1;
            @(negedge clk);
            lat++;
        end
        if (req_ready) rdy_bad = 1'b1;
        got_rd     = rsp_rdata;
        got_passes = rsp_passes;
        if (wr) model_write(act);
        check(got_passes == 6'(exp_p), {tag, " passes"}, got_passes, exp_p);
        check(lat == exp_p + 1, "R6 latency", lat, exp_p + 1);
        check(!rdy_bad, "R6 ready low while busy", rdy_bad, 0);
    endtask

    task automatic check_reads(input logic [31:0] act, input string tag);
        int bad = 0;
        logic [31:0] a_v = '0, e_v = '0;
        for (int l = 0; l < LANES; l++) begin
            logic [31:0] g = got_rd[l*WW +: WW];
            if (!act[l]) begin
                if (g != 0) begin bad++; a_v = g; e_v = 0; end
            end else if (known[t_addr[l]] && g != model[t_addr[l]]) begin
                bad++; a_v = g; e_v = model[t_addr[l]];
            end
        end
        check(bad == 0, tag, a_v, e_v);
    endtask

    task automatic clear_lanes();
        for (int l = 0; l < LANES; l++) begin
            t_addr[l] = '0; t_wd[l] = '0; t_be[l] = 4'hF;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
        $display("== %0d vectors applied, %0d miscompares ==", nchk + 1, nfail);
        $finish;
    end

    initial begin
        for (int w = 0; w < WORDS; w++) begin model[w] = '0; known[w] = 1'b0; end
        rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0;
        req_active = '0; req_addr = '0; req_wdata = '0; req_be = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        check(req_ready == 1'b1, "R11 reset ready", req_ready, 1);
        check(rsp_valid == 1'b0, "R11 reset rsp_valid", rsp_valid, 0);
        check(rsp_passes == 0, "R11 reset passes", rsp_passes, 0);

        // table walk
        for (int v = 0; v < NV; v++) begin
            for (int l = 0; l < LANES; l++) begin
                t_addr[l] = AW'(32'(VECS[v].base) + l * 32'(VECS[v].stride));
                t_wd[l]   = 32'hC300_0000 ^ (v << 20) ^ (l << 10) ^ 32'(t_addr[l]);
                t_be[l]   = 4'hF;
            end
            issue(VECS[v].wr, VECS[v].act, VECS[v].exp, $sformatf("R2/R3 vec%0d", v));
            if (!VECS[v].wr) check_reads(VECS[v].act, $sformatf("R1/R4/R9 vec%0d data", v));
        end

        // R5: bank 0 leaders by lowest pending lane, same word merged
        clear_lanes();
        t_addr[0] = 10'd0; t_addr[1] = 10'd32; t_addr[2] = 10'd0;
        t_addr[3] = 10'd64; t_addr[4] = 10'd32;
        issue(1'b0, 32'h1F, 3, "R5 mixed");
        check_reads(32'h1F, "R5 mixed data");

        // R7: same-word write collision, per-byte highest lane wins
        clear_lanes();
        for (int l = 0; l < 4; l++) t_addr[l] = 10'd100;
        t_wd[0] = 32'h1111_1111; t_be[0] = 4'hF;
        t_wd[1] = 32'h2222_2222; t_be[1] = 4'h3;
        t_wd[2] = 32'h3333_3333; t_be[2] = 4'h4;
        t_wd[3] = 32'h4444_4444; t_be[3] = 4'h1;
        issue(1'b1, 32'hF, 1, "R7 collide");
        clear_lanes();
        t_addr[0] = 10'd100;
        issue(1'b0, 32'h1, 1, "R7 readback");
        check(got_rd[31:0] == 32'h1133_2244, "R7 merged word", got_rd[31:0], 32'h1133_2244);

        // R8: partial byte write
        clear_lanes();
        t_addr[5] = 10'd100; t_wd[5] = 32'hAB00_00CD; t_be[5] = 4'b1000;
        issue(1'b1, 32'h20, 1, "R8 write");
        clear_lanes();
        t_addr[9] = 10'd100;
        issue(1'b0, 32'h200, 1, "R8 readback");
        check(got_rd[9*WW +: WW] == 32'hAB33_2244, "R8 byte lane", got_rd[9*WW +: WW], 32'hAB33_2244);

        // R9: inactive lane write has no effect
        clear_lanes();
        t_addr[0] = 10'd200; t_wd[0] = 32'h0000_0001;
        t_addr[1] = 10'd100; t_wd[1] = 32'hFFFF_FFFF;
        issue(1'b1, 32'h1, 1, "R9 write");
        clear_lanes();
        t_addr[0] = 10'd100; t_addr[1] = 10'd200;
        issue(1'b0, 32'h3, 1, "R9 readback");
        check(got_rd[31:0] == 32'hAB33_2244, "R9 untouched word", got_rd[31:0], 32'hAB33_2244);
        check(got_rd[63:32] == 32'h1, "R9 active word", got_rd[63:32], 1);

        // R12: same bank in consecutive requests stays single pass
        clear_lanes();
        t_addr[0] = 10'd0; t_addr[1] = 10'd32;
        issue(1'b0, 32'h1, 1, "R12 first");
        issue(1'b0, 32'h2, 1, "R12 second");
        check(got_rd[63:32] == model[32], "R12 data", got_rd[63:32], model[32]);

        // R11: count held while idle
        repeat (4) @(negedge clk);
        check(rsp_passes == 6'd1, "R11 passes held", rsp_passes, 1);
        check(req_ready == 1'b1, "R11 idle ready", req_ready, 1);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule